// File: doc/BRIEF.md
# Firmware Image Loader with Readback Verify

This block moves a training firmware image from a 32-bit source memory into a target memory that is only 16 bits wide. Each image has two parts: an instruction part and a data part. Each source word becomes two half-word writes. When both parts are copied, the block reads the target back half-word by half-word, rebuilds every word and compares it with the source. Every mismatch adds one to a saturating error count.

The host pulses `start` and gives an image type (0 = 1D image, 1 = 2D image), a source region base and the byte lengths of the two parts. For the 2D image the instruction part starts at a fixed byte offset inside the source region. The data part always follows directly after the instruction part. The block remembers which image type it loaded last. A request for that same type is answered with `done` at once, and the block makes no memory access.

Both memory ports read combinationally. The source address and the target address produce their read data in the same cycle.

Top module: `fw_image_loader`

## Requirements
- R1: A source word at target word address A is written as two consecutive `tgt_wr` cycles. The first writes bits [15:0] to A. The second writes bits [31:16] to A+1.
- R2: Instruction word k (k counting from 0) comes from source byte address S+4k and goes to target address IMEM_TGT+2k. Data word k comes from S+ilen+4k and goes to DMEM_TGT+2k. S is the instruction source start.
- R3: S equals `src_base` for type 0. For type 1, S equals `src_base` + IMG2_OFS (49152 bytes by default).
- R4: A load runs four passes in a fixed order: instruction copy, data copy, instruction verify, data verify. `tgt_wr` and `tgt_rd` are never high in the same cycle. `busy` is high during the load. `done` is a one-cycle pulse at the end.
- R5: During the verify passes, each word rebuilt as {read(A+1), read(A)} that differs from the source word adds one to `err_count`. The count carries over from the instruction verify into the data verify. It is cleared when a new load starts.
- R6: `err_count` saturates at its all-ones value.
- R7: A `start` whose type equals the last loaded type makes no target access. It pulses `done` in the next cycle and leaves `err_count` unchanged.
- R8: After reset, `busy`, `done` and `err_count` are 0. The first request always loads, whatever its type.
- R9: A `start` while `busy` is high is ignored. Only one `done` pulse follows, and the recorded last type is that of the running load.
- R10: A part of length 0 bytes makes no accesses. A length that is not a multiple of 4 is rounded up to whole words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle load request |
| img_type | input | 1 | Image type: 0 = 1D, 1 = 2D |
| src_base | input | SRC_AW | Byte base of the source image region |
| ilen | input | LEN_W | Instruction part length in bytes |
| dlen | input | LEN_W | Data part length in bytes |
| src_addr | output | SRC_AW | Source byte address |
| src_rdata | input | 32 | Source word at `src_addr` |
| tgt_addr | output | TGT_AW | Target half-word address |
| tgt_wr | output | 1 | Target write strobe |
| tgt_wdata | output | 16 | Target write data |
| tgt_rd | output | 1 | Target read strobe |
| tgt_rdata | input | 16 | Target half-word at `tgt_addr` |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| err_count | output | ERR_W | Saturating mismatch count |

## Verification
The bench builds the block with ERR_W = 3. The counter then saturates at 7, so a full-image write fault of twelve words can drive it past its limit. The target bases and the 2D offset keep their default values. The bench uses short lengths, so the two target windows fit in small bench arrays, and every half-word in them can be compared with the source pattern. A write-protect fault in the bench target model produces a known number of mismatches, split across the instruction and data verify passes.

// File: rtl/fwl_pkg.sv
// Shared types for the firmware image loader.
// Assumes: nothing beyond IEEE 1800-2017.
package fwl_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ICPY = 3'd1,
        PH_DCPY = 3'd2,
        PH_IVER = 3'd3,
        PH_DVER = 3'd4
    } phase_t;
endpackage

// File: rtl/fwl_type_track.sv
// Remembers the type of the last image that was loaded and flags a repeat request.
// Assumes: upd is high for one cycle when a load is accepted; resets to "nothing loaded".
module fwl_type_track (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic new_type,
    input  logic req_type,
    output logic hit
);
    logic valid_q;
    logic type_q;

    // Record the accepted type; reset leaves no valid type so the first request loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            type_q  <= 1'b0;
        end else if (upd) begin
            valid_q <= 1'b1;
            type_q  <= new_type;
        end
    end

    assign hit = valid_q && (type_q == req_type);

    // R8
    first_req_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_q) |-> 1'b0);
endmodule

// File: rtl/fwl_err_ctr.sv
// Saturating mismatch counter; cleared at the start of every load.
// Assumes: clr and inc are never high in the same cycle.
module fwl_err_ctr #(
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [ERR_W-1:0] count
);
    localparam logic [ERR_W-1:0] MAXV = '1;

    // Count mismatches, hold at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && count != MAXV) begin
            count <= count + 1'b1;
        end
    end

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count == MAXV) |=> count == MAXV);
    // R5
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/fwl_addr_gen.sv
// Builds source and target addresses from pass, byte offset and half select.
// Assumes: off steps by 4 bytes per word; the data part follows the instruction part in source.
module fwl_addr_gen
    import fwl_pkg::*;
#(
    parameter int              SRC_AW   = 32,
    parameter int              TGT_AW   = 20,
    parameter int              LEN_W    = 16,
    parameter logic [TGT_AW-1:0] IMEM_TGT = 20'h50000,
    parameter logic [TGT_AW-1:0] DMEM_TGT = 20'h54000,
    parameter logic [SRC_AW-1:0] IMG2_OFS = 32'd49152
) (
    input  phase_t            phase,
    input  logic [LEN_W:0]    off,
    input  logic              hi,
    input  logic              img_type,
    input  logic [SRC_AW-1:0] src_base,
    input  logic [LEN_W-1:0]  ilen,
    output logic              is_data,
    output logic [SRC_AW-1:0] src_addr,
    output logic [TGT_AW-1:0] tgt_addr
);
    localparam int OFF_W = LEN_W + 1;

    logic [SRC_AW-1:0] inst_start;
    logic [SRC_AW-1:0] part_start;
    logic [TGT_AW-1:0] tgt_base;
    logic [OFF_W-1:0]  half_idx;

    // Pick the source and target start of the current part and add the offset.
    always_comb begin
        is_data    = (phase == PH_DCPY) || (phase == PH_DVER);
        inst_start = src_base + (img_type ? IMG2_OFS : '0);
        part_start = is_data ? inst_start + SRC_AW'(ilen) : inst_start;
        tgt_base   = is_data ? DMEM_TGT : IMEM_TGT;
        half_idx   = off >> 1;
        src_addr   = part_start + SRC_AW'(off);
        tgt_addr   = tgt_base + TGT_AW'(half_idx) + TGT_AW'(hi);
    end
endmodule

// File: rtl/fw_image_loader.sv
// Copies a two-part firmware image from 32-bit source to 16-bit target memory,
// then verifies it by readback and counts mismatching words.
// Assumes: both memory ports return read data combinationally in the same cycle.
module fw_image_loader
    import fwl_pkg::*;
#(
    parameter int                SRC_AW   = 32,
    parameter int                TGT_AW   = 20,
    parameter int                LEN_W    = 16,
    parameter int                ERR_W    = 16,
    parameter logic [TGT_AW-1:0] IMEM_TGT = 20'h50000,
    parameter logic [TGT_AW-1:0] DMEM_TGT = 20'h54000,
    parameter logic [SRC_AW-1:0] IMG2_OFS = 32'd49152
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              img_type,
    input  logic [SRC_AW-1:0] src_base,
    input  logic [LEN_W-1:0]  ilen,
    input  logic [LEN_W-1:0]  dlen,
    output logic [SRC_AW-1:0] src_addr,
    input  logic [31:0]       src_rdata,
    output logic [TGT_AW-1:0] tgt_addr,
    output logic              tgt_wr,
    output logic [15:0]       tgt_wdata,
    output logic              tgt_rd,
    input  logic [15:0]       tgt_rdata,
    output logic              busy,
    output logic              done,
    output logic [ERR_W-1:0]  err_count
);
    localparam int OFF_W = LEN_W + 1;

    phase_t              phase_q;
    logic [OFF_W-1:0]    off_q;
    logic                hi_q;
    logic                type_q;
    logic [SRC_AW-1:0]   base_q;
    logic [LEN_W-1:0]    ilen_q;
    logic [LEN_W-1:0]    dlen_q;
    logic [15:0]         lo_q;
    logic                is_data;
    logic                at_end;
    logic                copying;
    logic                checking;
    logic                type_hit;
    logic                accept;
    logic                mismatch;

    fwl_type_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (accept),
        .new_type (img_type),
        .req_type (img_type),
        .hit      (type_hit)
    );

    fwl_addr_gen #(
        .SRC_AW   (SRC_AW),
        .TGT_AW   (TGT_AW),
        .LEN_W    (LEN_W),
        .IMEM_TGT (IMEM_TGT),
        .DMEM_TGT (DMEM_TGT),
        .IMG2_OFS (IMG2_OFS)
    ) u_addr (
        .phase    (phase_q),
        .off      (off_q),
        .hi       (hi_q),
        .img_type (type_q),
        .src_base (base_q),
        .ilen     (ilen_q),
        .is_data  (is_data),
        .src_addr (src_addr),
        .tgt_addr (tgt_addr)
    );

    fwl_err_ctr #(.ERR_W(ERR_W)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (mismatch),
        .count (err_count)
    );

    // Decode the pass: end-of-part test, strobes, write data, mismatch.
    always_comb begin
        busy      = (phase_q != PH_IDLE);
        at_end    = off_q >= {1'b0, (is_data ? dlen_q : ilen_q)};
        copying   = (phase_q == PH_ICPY) || (phase_q == PH_DCPY);
        checking  = (phase_q == PH_IVER) || (phase_q == PH_DVER);
        tgt_wr    = copying && !at_end;
        tgt_rd    = checking && !at_end;
        tgt_wdata = hi_q ? src_rdata[31:16] : src_rdata[15:0];
        accept    = start && !busy && !type_hit;
        mismatch  = tgt_rd && hi_q && ({tgt_rdata, lo_q} != src_rdata);
    end

    // Sequence the four passes, step the offset per word, pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            off_q   <= '0;
            hi_q    <= 1'b0;
            type_q  <= 1'b0;
            base_q  <= '0;
            ilen_q  <= '0;
            dlen_q  <= '0;
            lo_q    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase_q == PH_IDLE) begin
                if (start && type_hit) begin
                    done <= 1'b1;
                end else if (accept) begin
                    phase_q <= PH_ICPY;
                    off_q   <= '0;
                    hi_q    <= 1'b0;
                    type_q  <= img_type;
                    base_q  <= src_base;
                    ilen_q  <= ilen;
                    dlen_q  <= dlen;
                end
            end else if (at_end) begin
                off_q <= '0;
                hi_q  <= 1'b0;
                case (phase_q)
                    PH_ICPY: phase_q <= PH_DCPY;
                    PH_DCPY: phase_q <= PH_IVER;
                    PH_IVER: phase_q <= PH_DVER;
                    default: begin
                        phase_q <= PH_IDLE;
                        done    <= 1'b1;
                    end
                endcase
            end else if (!hi_q) begin
                hi_q <= 1'b1;
                lo_q <= tgt_rdata;
            end else begin
                hi_q  <= 1'b0;
                off_q <= off_q + OFF_W'(4);
            end
        end
    end

    // R1
    hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr && hi_q) |-> ($past(tgt_wr) && tgt_addr == $past(tgt_addr) + 1'b1));
    // R2
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tgt_wr || tgt_rd) && hi_q) |-> $stable(src_addr));
    // R4
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tgt_wr, tgt_rd}));
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && type_hit) |=> (done && !busy));
endmodule

// File: tb/fw_image_loader_test.sv
// Directed bench for fw_image_loader: one task per scenario, each checking its results.
module fw_image_loader_test;
    localparam int ERR_W = 3;
    localparam logic [19:0] IMEM_T = 20'h50000;
    localparam logic [19:0] DMEM_T = 20'h54000;
    localparam logic [31:0] OFS2   = 32'd49152;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        img_type = 1'b0;
    logic [31:0] src_base = '0;
    logic [15:0] ilen = '0;
    logic [15:0] dlen = '0;
    logic [31:0] src_addr;
    logic [31:0] src_rdata;
    logic [19:0] tgt_addr;
    logic        tgt_wr;
    logic [15:0] tgt_wdata;
    logic        tgt_rd;
    logic [15:0] tgt_rdata;
    logic        busy;
    logic        done;
    logic [ERR_W-1:0] err_count;

    fw_image_loader #(.ERR_W(ERR_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_type(img_type),
        .src_base(src_base), .ilen(ilen), .dlen(dlen),
        .src_addr(src_addr), .src_rdata(src_rdata),
        .tgt_addr(tgt_addr), .tgt_wr(tgt_wr), .tgt_wdata(tgt_wdata),
        .tgt_rd(tgt_rd), .tgt_rdata(tgt_rdata),
        .busy(busy), .done(done), .err_count(err_count)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [31:0] seed = 32'h1234_0000;
    logic [15:0] imem_t [256];
    logic [15:0] dmem_t [256];
    logic fill_req = 1'b0;
    logic wp_all = 1'b0;
    logic [19:0] wp_addr = '1;
    int  n_wr = 0, n_rd = 0, n_bad = 0, n_order = 0, stage_q = 0, n_done = 0;

    assign src_rdata = (src_addr * 32'h9E3779B1) ^ seed;

    function automatic logic [31:0] fsrc(logic [31:0] a, logic [31:0] s);
        return (a * 32'h9E3779B1) ^ s;
    endfunction

    // Combinational target read model.
    always_comb begin
        tgt_rdata = 16'h0;
        if (tgt_addr - IMEM_T < 20'd256) tgt_rdata = imem_t[8'(tgt_addr - IMEM_T)];
        else if (tgt_addr - DMEM_T < 20'd256) tgt_rdata = dmem_t[8'(tgt_addr - DMEM_T)];
    end

    // Target write model, access counters and pass-order tracking.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (done) n_done <= n_done + 1;
        if (fill_req) begin
            for (int i = 0; i < 256; i++) begin
                imem_t[i] <= 16'h0;
                dmem_t[i] <= 16'h0;
            end
            stage_q <= 0;
        end else if (tgt_wr || tgt_rd) begin
            automatic bit in_i = (tgt_addr - IMEM_T) < 20'd256;
            automatic bit in_d = (tgt_addr - DMEM_T) < 20'd256;
            automatic int st = tgt_wr ? (in_i ? 0 : 1) : (in_i ? 2 : 3);
            if (!in_i && !in_d) n_bad <= n_bad + 1;
            if (st < stage_q) n_order <= n_order + 1;
            stage_q <= st;
            if (tgt_wr) begin
                n_wr <= n_wr + 1;
                if (!wp_all && tgt_addr != wp_addr) begin
                    if (in_i) imem_t[8'(tgt_addr - IMEM_T)] <= tgt_wdata;
                    else if (in_d) dmem_t[8'(tgt_addr - DMEM_T)] <= tgt_wdata;
                end
            end else begin
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        @(negedge clk); fill_req = 1'b1;
        @(negedge clk); fill_req = 1'b0;
        n_wr = 0; n_rd = 0; n_bad = 0; n_order = 0; n_done = 0;
    endtask

    // Issue a request and wait for done; returns negedges waited.
    task automatic run(input logic t, input logic [31:0] b, input logic [15:0] il,
                       input logic [15:0] dl, output int waited);
        @(negedge clk);
        img_type = t; src_base = b; ilen = il; dlen = dl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        @(negedge clk);
    endtask

    function automatic int words(input logic [15:0] len);
        return (int'(len) + 3) / 4;
    endfunction

    // Compare every target half-word of both parts with the source pattern.
    task automatic check_image(input logic t, input logic [31:0] b, input logic [15:0] il,
                               input logic [15:0] dl, input string req);
        automatic logic [31:0] s0 = b + (t ? OFS2 : 32'd0);
        automatic int bad = 0;
        for (int k = 0; k < words(il); k++) begin
            automatic logic [31:0] w = fsrc(s0 + 32'(4 * k), seed);
            if (imem_t[2*k] != w[15:0] || imem_t[2*k+1] != w[31:16]) bad++;
        end
        for (int k = 0; k < words(dl); k++) begin
            automatic logic [31:0] w = fsrc(s0 + 32'(il) + 32'(4 * k), seed);
            if (dmem_t[2*k] != w[15:0] || dmem_t[2*k+1] != w[31:16]) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R8 busy after reset", busy, 0);
        chk(done == 1'b0, "R8 done after reset", done, 0);
        chk(err_count == 0, "R8 err after reset", err_count, 0);
    endtask

    task automatic t_first_load();
        int w;
        clear_mem();
        run(1'b0, 32'h0000_1000, 16'd16, 16'd8, w);
        chk(w < 5000, "R8 first load completes", w, 0);
        check_image(1'b0, 32'h0000_1000, 16'd16, 16'd8, "R1 R2 image contents");
        chk(n_wr == 12, "R1 write count", n_wr, 12);
        chk(n_rd == 12, "R5 readback count", n_rd, 12);
        chk(n_order == 0 && n_bad == 0, "R4 pass order", n_order + n_bad, 0);
        chk(err_count == 0, "R5 clean verify", err_count, 0);
        chk(n_done == 1 && busy == 0, "R4 single done pulse", n_done, 1);
        chk(imem_t[8] == 16'h0 && dmem_t[4] == 16'h0, "R2 no write past length",
            imem_t[8] | dmem_t[4], 0);
    endtask

    task automatic t_skip();
        int w;
        clear_mem();
        seed = seed ^ 32'h00FF_0000;
        run(1'b0, 32'h0000_1000, 16'd16, 16'd8, w);
        chk(w == 0, "R7 skip done next cycle", w, 0);
        chk(n_wr == 0 && n_rd == 0, "R7 skip no access", n_wr + n_rd, 0);
        chk(err_count == 0, "R7 skip keeps err", err_count, 0);
    endtask

    task automatic t_type2_faults();
        int w;
        clear_mem();
        wp_addr = IMEM_T + 20'd3;
        run(1'b1, 32'h0000_2000, 16'd16, 16'd8, w);
        wp_addr = DMEM_T + 20'd2;
        chk(err_count == 1, "R5 one instruction fault", err_count, 1);
        // second load of other type with a data-part fault; count must restart
        clear_mem();
        run(1'b0, 32'h0000_1000, 16'd16, 16'd8, w);
        chk(err_count == 1, "R5 cleared then one data fault", err_count, 1);
        clear_mem();
        wp_addr = IMEM_T + 20'd1;
        run(1'b1, 32'h0000_2000, 16'd16, 16'd12, w);
        wp_addr = '1;
        chk(err_count == 1, "R5 instr fault only", err_count, 1);
        imem_t[1] = fsrc(32'h0000_2000 + OFS2, seed) >> 16;
        check_image(1'b1, 32'h0000_2000, 16'd16, 16'd12, "R3 2D offset contents");
    endtask

    task automatic t_accumulate();
        int w;
        clear_mem();
        wp_addr = IMEM_T + 20'd0;
        run(1'b0, 32'h0000_1000, 16'd8, 16'd8, w);
        chk(err_count == 1, "R5 carry into data verify (instr)", err_count, 1);
        clear_mem();
        wp_all = 1'b1;
        wp_addr = '1;
        run(1'b1, 32'h0000_3000, 16'd8, 16'd4, w);
        chk(err_count == 3, "R5 accumulate across verifies", err_count, 3);
        wp_all = 1'b0;
    endtask

    task automatic t_saturate();
        int w;
        clear_mem();
        wp_all = 1'b1;
        run(1'b0, 32'h0000_4000, 16'd40, 16'd8, w);
        wp_all = 1'b0;
        chk(err_count == 7, "R6 saturate at all-ones", err_count, 7);
    endtask

    task automatic t_busy_start();
        int w;
        clear_mem();
        @(negedge clk);
        img_type = 1'b1; src_base = 32'h0000_1000; ilen = 16'd16; dlen = 16'd8; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        img_type = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        w = 0;
        while (busy && w < 5000) begin @(negedge clk); w++; end
        repeat (4) @(negedge clk);
        chk(n_done == 1, "R9 single done", n_done, 1);
        clear_mem();
        run(1'b1, 32'h0000_1000, 16'd16, 16'd8, w);
        chk(n_wr == 0 && w == 0, "R9 running type recorded", n_wr, 0);
    endtask

    task automatic t_lengths();
        int w;
        clear_mem();
        run(1'b0, 32'h0000_5000, 16'd6, 16'd0, w);
        chk(n_wr == 4 && n_rd == 4, "R10 round up, empty data part", n_wr, 4);
        chk(dmem_t[0] == 16'h0, "R10 empty part untouched", dmem_t[0], 0);
        check_image(1'b0, 32'h0000_5000, 16'd6, 16'd0, "R10 rounded contents");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_load();
        t_skip();
        t_type2_faults();
        t_accumulate();
        t_saturate();
        t_busy_start();
        t_lengths();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cycles > 100000);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule